// File: doc/BRIEF.md
# GPIO Controller with Interrupt Sensing

This block is a 32-pin general-purpose I/O controller on a simple 32-bit register bus. The bus has an address, a write enable, write data and a read data word that follows the address combinationally. Each pin is either an output or an input. An output pin is driven from the data register. An input pin is sampled from its pad through a two-flop synchronizer, and its level can be read back. Every access is a full 32-bit word.

Input pins can raise interrupts. Each pin has a 2-bit mode that selects level or edge sensing and the active polarity. A per-pin any-edge override, which is present only when a build parameter asks for it, takes priority over that mode. Status bits are sticky and are cleared by writing 1. A level condition that is still present sets its bit again on the next clock. Status bits are ANDed with a mask register. The result drives a single interrupt output, or two outputs split by pin halves when the split build option is chosen.

Register offsets (byte addresses): data 0x00, direction 0x04, pad status 0x08, mode word for pins 0-15 at 0x0C, mode word for pins 16-31 at 0x10, mask 0x14, status 0x18, any-edge 0x1C.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the data, direction, both mode words, the mask and the any-edge register read 0. padOe and padOut are 0, and irqLo and irqHi are low.
- R2: One clock after a write, padOut equals the data register and padOe equals the direction register (bit = 1 means output).
- R3: A pad change is visible in a pad status read two clock edges after it is driven, and not after one. A pad status read returns the pad levels with output pins forced to 0. A data read returns the data bit for output pins and the pad bit for input pins.
- R4: Pin n's mode is bits 2n+1:2n of {word 0x10, word 0x0C}. Mode 00 sets the status bit on every clock on which the pin is low. Mode 01 does the same while the pin is high.
- R5: Mode 10 sets the status bit on a rising edge and mode 11 on a falling edge, on the third clock edge after the pad changes. The opposite edge sets nothing.
- R6: When a pin's any-edge bit is 1, both rising and falling edges set its status bit, whatever its mode.
- R7: A write to status clears each bit written as 1 and leaves bits written as 0 unchanged. A level condition that is still active keeps its bit set through the clear.
- R8: A pin whose direction bit is 1 never sets its status bit.
- R9: Without the split option, irqLo is the OR of (status AND mask) and irqHi is 0. With the split option, irqLo covers pins 0-15 and irqHi covers pins 16-31.
- R10: Without the any-edge option, the any-edge register reads 0 and writes to it have no effect on detection.
- R11: Reads of offsets whose low two bits are nonzero, or that lie above 0x1C, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr |
| padIn | input | DATA_W | Asynchronous pad input levels |
| padOut | output | DATA_W | Pad output levels |
| padOe | output | DATA_W | Pad output enables |
| irqLo | output | 1 | Interrupt (all pins, or pins 0-15 when split) |
| irqHi | output | 1 | Interrupt for pins 16-31 when split, else 0 |

## Verification
The assertions check properties on every cycle. padOe and padOut follow the writes made to them. Unmapped offsets read 0, and so does a missing any-edge register. A zero mask silences both interrupt outputs, and irqHi stays low when the outputs are not split. The bench scenarios cover the behaviour that depends on history. This includes the synchronizer latency, the cycle in which each edge mode sets its status bit, and whether the opposite edge is ignored. It also includes the any-edge override, write-1-to-clear with a level condition that re-asserts, output pins that are kept out of detection, and which pin half drives which output when split.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFF_DATA  = 0;
  localparam int unsigned OFF_DIR   = 4;
  localparam int unsigned OFF_PAD   = 8;
  localparam int unsigned OFF_CFGLO = 12;
  localparam int unsigned OFF_CFGHI = 16;
  localparam int unsigned OFF_MASK  = 20;
  localparam int unsigned OFF_STAT  = 24;
  localparam int unsigned OFF_ANY   = 28;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_PAD, RD_CFGLO,
    RD_CFGHI, RD_MASK, RD_STAT, RD_ANY
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrCfgLo;
    logic   wrCfgHi;
    logic   wrMask;
    logic   wrStat;
    logic   wrAny;
    rdSel_e rdSel;
  } ctlStrb_t;
endpackage

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter bit HAS_ANY_EDGE = 1'b1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctlStrb_t          strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (busAddr == ADDR_W'(OFF_DATA)) begin
      strb.wrData = busWe;  strb.rdSel = RD_DATA;
    end else if (busAddr == ADDR_W'(OFF_DIR)) begin
      strb.wrDir = busWe;   strb.rdSel = RD_DIR;
    end else if (busAddr == ADDR_W'(OFF_PAD)) begin
      strb.rdSel = RD_PAD;
    end else if (busAddr == ADDR_W'(OFF_CFGLO)) begin
      strb.wrCfgLo = busWe; strb.rdSel = RD_CFGLO;
    end else if (busAddr == ADDR_W'(OFF_CFGHI)) begin
      strb.wrCfgHi = busWe; strb.rdSel = RD_CFGHI;
    end else if (busAddr == ADDR_W'(OFF_MASK)) begin
      strb.wrMask = busWe;  strb.rdSel = RD_MASK;
    end else if (busAddr == ADDR_W'(OFF_STAT)) begin
      strb.wrStat = busWe;  strb.rdSel = RD_STAT;
    end else if (busAddr == ADDR_W'(OFF_ANY) && HAS_ANY_EDGE) begin
      strb.wrAny = busWe;   strb.rdSel = RD_ANY;
    end
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SYNC_STAGES  = 2,
  parameter bit HAS_ANY_EDGE = 1'b1,
  parameter bit SPLIT_IRQ    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrb_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  output logic              irqLo,
  output logic              irqHi
);
  localparam int CFG_W = 2 * DATA_W;
  localparam int HALF  = DATA_W / 2;

  logic [SYNC_STAGES-1:0][DATA_W-1:0] syncChain;
  logic [DATA_W-1:0] padLvl, prevLvl, dataReg, dirReg, maskReg, statReg, anyReg;
  logic [DATA_W-1:0] setReq, clrMask, masked;
  logic [CFG_W-1:0]  cfgReg;

  assign padLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncChain <= '0;
      prevLvl   <= '0;
    end else begin
      syncChain[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
      prevLvl <= padLvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
      dirReg  <= '0;
      maskReg <= '0;
      cfgReg  <= '0;
      statReg <= '0;
    end else begin
      if (strb.wrData)  dataReg <= busWdata;
      if (strb.wrDir)   dirReg  <= busWdata;
      if (strb.wrMask)  maskReg <= busWdata;
      if (strb.wrCfgLo) cfgReg[DATA_W-1:0]     <= busWdata;
      if (strb.wrCfgHi) cfgReg[CFG_W-1:DATA_W] <= busWdata;
      statReg <= (statReg & ~clrMask) | setReq;
    end
  end

  assign clrMask = strb.wrStat ? busWdata : '0;

  generate
    if (HAS_ANY_EDGE) begin : gAny
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          anyReg <= '0;
        else if (strb.wrAny) anyReg <= busWdata;
      end
    end else begin : gNoAny
      assign anyReg = '0;
    end
  endgenerate

  // Per-pin condition: any-edge override, then edge or level by mode.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : gPin
      logic [1:0] mode;
      logic       changed, edgeHit, lvlHit;
      assign mode    = cfgReg[2*i +: 2];
      assign changed = padLvl[i] ^ prevLvl[i];
      assign edgeHit = anyReg[i] ? changed
                                 : (mode[1] & changed & (padLvl[i] != mode[0]));
      assign lvlHit  = ~anyReg[i] & ~mode[1] & (padLvl[i] == mode[0]);
      assign setReq[i] = ~dirReg[i] & (edgeHit | lvlHit);
    end
  endgenerate

  always_comb begin
    case (strb.rdSel)
      RD_DATA:  busRdata = (dataReg & dirReg) | (padLvl & ~dirReg);
      RD_DIR:   busRdata = dirReg;
      RD_PAD:   busRdata = padLvl & ~dirReg;
      RD_CFGLO: busRdata = cfgReg[DATA_W-1:0];
      RD_CFGHI: busRdata = cfgReg[CFG_W-1:DATA_W];
      RD_MASK:  busRdata = maskReg;
      RD_STAT:  busRdata = statReg;
      RD_ANY:   busRdata = anyReg;
      default:  busRdata = '0;
    endcase
  end

  assign padOut = dataReg;
  assign padOe  = dirReg;
  assign masked = statReg & maskReg;

  generate
    if (SPLIT_IRQ) begin : gSplit
      assign irqLo = |masked[HALF-1:0];
      assign irqHi = |masked[DATA_W-1:HALF];
    end else begin : gJoin
      assign irqLo = |masked;
      assign irqHi = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 32,
  parameter int SYNC_STAGES  = 2,
  parameter bit HAS_ANY_EDGE = 1'b1,
  parameter bit SPLIT_IRQ    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  output logic              irqLo,
  output logic              irqHi
);
  ctlStrb_t strb;

  gpio_irq_ctl #(.ADDR_W(ADDR_W), .HAS_ANY_EDGE(HAS_ANY_EDGE)) uCtl (
    .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  gpio_irq_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
    .HAS_ANY_EDGE(HAS_ANY_EDGE), .SPLIT_IRQ(SPLIT_IRQ)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqLo(irqLo), .irqHi(irqHi)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 32,
  parameter bit HAS_ANY_EDGE = 1'b1,
  parameter bit SPLIT_IRQ    = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] padOut,
  input logic [DATA_W-1:0] padOe,
  input logic              irqLo,
  input logic              irqHi
);
  logic mapped;
  assign mapped = (busAddr[1:0] == 2'b00) && (busAddr <= ADDR_W'(OFF_ANY));

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_DIR)) |=> (padOe == $past(busWdata)));  // R2
  AST_OUT_TRACKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_DATA)) |=> (padOut == $past(busWdata)));  // R2
  AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_MASK) && busWdata == '0) |=> (!irqLo && !irqHi));  // R9
  AST_JOINED_HI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!SPLIT_IRQ) |-> !irqHi);  // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (busRdata == '0));  // R11
  AST_NO_ANY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_ANY_EDGE && busAddr == ADDR_W'(OFF_ANY)) |-> (busRdata == '0));  // R10
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .HAS_ANY_EDGE(HAS_ANY_EDGE), .SPLIT_IRQ(SPLIT_IRQ)
) uChk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .padOut(padOut), .padOe(padOe),
  .irqLo(irqLo), .irqHi(irqHi)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_PAD = 6'h08,
    A_CLO = 6'h0C, A_CHI = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18, A_ANY = 6'h1C;

  logic clk = 1'b0, rst_n = 1'b0, busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0, padIn = '0;
  logic [31:0] rd0, rd1, out0, oe0, out1, oe1, rv0, rv1;
  logic irqLo0, irqHi0, irqLo1, irqHi1;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(rd0), .padIn(padIn), .padOut(out0),
    .padOe(oe0), .irqLo(irqLo0), .irqHi(irqHi0));

  gpio_irq_ctrl #(.HAS_ANY_EDGE(1'b0), .SPLIT_IRQ(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(rd1), .padIn(padIn), .padOut(out1),
    .padOe(oe1), .irqLo(irqLo1), .irqHi(irqHi1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    busAddr = a; #1; rv0 = rd0; rv1 = rd1;
  endtask

  task automatic setPad(input logic [31:0] v);
    @(negedge clk); padIn = v;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(A_DATA); chk("R1 data", rv0, 0);
    rd(A_DIR);  chk("R1 dir", rv0, 0);
    rd(A_CLO);  chk("R1 cfglo", rv0, 0);
    rd(A_CHI);  chk("R1 cfghi", rv0, 0);
    rd(A_MASK); chk("R1 mask", rv0, 0);
    rd(A_ANY);  chk("R1 anyedge", rv0, 0);
    chk("R1 padOe", oe0, 0);
    chk("R1 padOut", out0, 0);
    chk("R1 irq", {30'd0, irqHi0, irqLo0}, 0);
  endtask

  task automatic t_outputs;
    wr(A_DIR, 32'hFFFF0000);
    wr(A_DATA, 32'h12345678);
    chk("R2 padOe", oe0, 32'hFFFF0000);
    chk("R2 padOut", out0, 32'h12345678);
    setPad(32'h5555ABCD);
    waitN(1); rd(A_PAD); chk("R3 pad after one edge", rv0, 0);
    waitN(1); rd(A_PAD); chk("R3 pad masked to inputs", rv0, 32'h0000ABCD);
    rd(A_DATA); chk("R3 data mix", rv0, 32'h1234ABCD);
    wr(A_DIR, 0); setPad(0); waitN(3);
  endtask

  task automatic t_level;
    wr(A_CLO, 32'h00000400);   // pin5 mode 01
    wr(A_CHI, 32'h0);
    wr(A_MASK, 32'h1 << 5);
    wr(A_STAT, 32'hFFFFFFFF);
    rd(A_STAT);
    chk("R4 high-level idle", rv0[5], 0);
    chk("R4 low-level upper pin", rv0[20], 1);
    chk("R9 irq idle", irqLo0, 0);
    setPad(32'h1 << 5); waitN(3);
    rd(A_STAT); chk("R4 high-level set", rv0[5], 1);
    chk("R9 irq raised", irqLo0, 1);
    wr(A_STAT, 32'h1 << 5);
    rd(A_STAT); chk("R7 level re-asserts", rv0[5], 1);
    setPad(0); waitN(3);
    wr(A_STAT, 32'h1 << 5);
    rd(A_STAT); chk("R7 cleared", rv0[5], 0);
    chk("R9 irq dropped", irqLo0, 0);
  endtask

  task automatic t_edge;
    wr(A_CLO, 32'h00000020);   // pin2 mode 10
    wr(A_CHI, 32'h00000030);   // pin18 mode 11
    wr(A_MASK, 0);
    wr(A_STAT, 32'hFFFFFFFF);
    rd(A_STAT); chk("R5 no level in edge mode", {30'd0, rv0[18], rv0[2]}, 0);
    setPad(32'h1 << 18); waitN(3);
    rd(A_STAT); chk("R5 rise ignored by falling mode", rv0[18], 0);
    setPad((32'h1 << 18) | (32'h1 << 2)); waitN(2);
    rd(A_STAT); chk("R5 rising not yet", rv0[2], 0);
    waitN(1);
    rd(A_STAT); chk("R5 rising set", rv0[2], 1);
    wr(A_STAT, ~(32'h1 << 2));
    rd(A_STAT); chk("R7 zero bit kept", rv0[2], 1);
    wr(A_STAT, 32'h1 << 2);
    rd(A_STAT); chk("R7 one bit cleared", rv0[2], 0);
    setPad(32'h1 << 2); waitN(3);
    rd(A_STAT); chk("R5 falling set", rv0[18], 1);
    setPad(0); waitN(3);
    rd(A_STAT); chk("R5 fall ignored by rising mode", rv0[2], 0);
  endtask

  task automatic t_anyedge;
    wr(A_CLO, 32'h00080000);   // pin9 mode 10
    wr(A_CHI, 0);
    wr(A_ANY, 32'h1 << 9);
    rd(A_ANY);
    chk("R6 any-edge readback", rv0, 32'h200);
    chk("R10 absent any-edge reads 0", rv1, 0);
    setPad(32'h1 << 9); waitN(3);
    wr(A_STAT, 32'h1 << 9);
    rd(A_STAT); chk("R6 cleared before fall", rv0[9], 0);
    setPad(0); waitN(3);
    rd(A_STAT);
    chk("R6 falling edge with override", rv0[9], 1);
    chk("R10 write ignored, fall not seen", rv1[9], 0);
    wr(A_ANY, 0);
  endtask

  task automatic t_outpin;
    wr(A_DIR, 32'h1 << 12);
    wr(A_CLO, 32'h01000000);   // pin12 mode 01
    setPad(32'h1 << 12); waitN(3);
    wr(A_STAT, 32'hFFFFFFFF);
    rd(A_STAT); chk("R8 output pin no status", rv0[12], 0);
    rd(A_PAD);  chk("R8 output pin pad reads 0", rv0[12], 0);
    wr(A_DIR, 0); waitN(1);
    rd(A_STAT); chk("R8 becomes input, level sets", rv0[12], 1);
    setPad(0); waitN(3);
  endtask

  task automatic t_split;
    wr(A_CLO, 32'h00000040);   // pin3 mode 01
    wr(A_CHI, 32'h00000004);   // pin17 mode 01
    wr(A_MASK, 32'h1 << 3);
    setPad((32'h1 << 3) | (32'h1 << 17)); waitN(3);
    chk("R9 joined low half", {30'd0, irqHi0, irqLo0}, 2'b01);
    chk("R9 split low half", {30'd0, irqHi1, irqLo1}, 2'b01);
    wr(A_MASK, 32'h1 << 17);
    chk("R9 joined upper pin", {30'd0, irqHi0, irqLo0}, 2'b01);
    chk("R9 split upper pin", {30'd0, irqHi1, irqLo1}, 2'b10);
    wr(A_MASK, 0);
    chk("R9 all masked", {28'd0, irqHi1, irqLo1, irqHi0, irqLo0}, 0);
    setPad(0); waitN(3);
  endtask

  task automatic t_unmapped;
    rd(6'h20); chk("R11 offset 0x20", rv0, 0);
    rd(6'h3C); chk("R11 offset 0x3C", rv0, 0);
    rd(6'h05); chk("R11 offset 0x05", rv0, 0);
    rd(6'h1E); chk("R11 offset 0x1E", rv0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitN(3);
    rst_n = 1'b1;
    waitN(1);
    t_reset();
    t_outputs();
    t_level();
    t_edge();
    t_anyedge();
    t_outpin();
    t_split();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule